// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general-purpose register store of a processor core that switches between a user/system context and five exception contexts. Software always sees sixteen 32-bit registers, numbered 0 to 15. Which physical flop row a number selects depends on the processor mode presented on `mode_i`.

The fast-interrupt mode swaps in private copies of registers 8 through 14. The other four exception modes swap in only their own stack pointer (13) and link register (14). Registers 0 to 7 and register 15 are the same storage in every mode. Register 15 is plain storage here, and nothing increments it.

The block also holds the current status word and one saved status word for each exception mode. An exception-entry strobe names a target mode. In a single clock it saves the current status word into that mode's saved status word and loads a supplied return address into that mode's register 14.

The file has two combinational read ports and one clocked write port. Each read port passes a same-cycle write straight through.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low, the block clears all 31 physical general registers and the five saved status words to zero, and loads the current status word with parameter `CPSR_INIT`.
- R2: Both read ports are combinational in index and mode. A write with `we` high is stored on the rising clock edge and is visible from the next cycle.
- R3: Registers 0 to 7 and 15 select the same storage in every mode. Mode codes are: 0, 6 and 7 = user/system, 1 = fast interrupt, 2 = interrupt, 3 = supervisor, 4 = abort, 5 = undefined.
- R4: In mode 1, registers 8 to 14 select a private bank of seven registers, separate from the user/system copies.
- R5: Modes 2 to 5 each have a private register 13 and register 14. In these modes, registers 8 to 12 select the user/system copies.
- R6: If a read index selects the same physical register as a write in the same cycle, the read returns the data being written. The saved status read port behaves the same way.
- R7: Each of modes 1 to 5 has its own saved status word, written through `spsr_we` in that mode. In a user/system mode, `spsr_o` reads zero and a saved status write changes nothing.
- R8: With `exc_take` high and `exc_mode` in 1 to 5, the next edge copies the current status word into that mode's saved status word and `exc_ret` into that mode's register 14. If a register or saved status write in the same cycle targets the same location, the exception data wins. An `exc_take` with a user/system `exc_mode` has no effect.
- R9: `cpsr_we` loads `cpsr_wdata` into the current status word on the clock edge. `cpsr_o` shows the registered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Current processor mode code |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | DW | Read port A data |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | DW | Read port B data |
| we | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | DW | Register write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | DW | Current status write data |
| cpsr_o | output | DW | Current status word |
| spsr_we | input | 1 | Saved status write enable for the current mode |
| spsr_wdata | input | DW | Saved status write data |
| spsr_o | output | DW | Saved status word of the current mode |
| exc_take | input | 1 | Exception-entry strobe |
| exc_mode | input | 3 | Target mode of the exception |
| exc_ret | input | DW | Return address loaded into the target register 14 |

## Verification
The hardest case to reach is a clash inside one cycle. An exception entry and an ordinary write both land on the same banked register 14 or the same saved status word, while a read port looks at that location through the bypass. Only one mode and index combination out of many produces this. The random stimulus draws the write index, the read indices and the exception target from small ranges biased toward 13 and 14, and it fires exception entries often, so these collisions happen regularly. Directed steps then force the exact clash in a known mode and check the winner against constants.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter logic [DW-1:0] CPSR_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          cpsr_we,
  input  logic [DW-1:0] cpsr_wdata,
  output logic [DW-1:0] cpsr_o,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wdata,
  output logic [DW-1:0] spsr_o,
  input  logic          exc_take,
  input  logic [2:0]    exc_mode,
  input  logic [DW-1:0] exc_ret
);
  localparam int NPHYS = 31;
  localparam int NSAVED = 5;

  localparam logic [2:0] M_FIQ = 3'd1;

  logic [DW-1:0] gpr   [NPHYS];
  logic [DW-1:0] saved [NSAVED];
  logic [DW-1:0] cur_st;

  function automatic logic banked_mode(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction

  function automatic logic [2:0] saved_slot(input logic [2:0] m);
    return m - 3'd1;
  endfunction

  function automatic logic [4:0] phys(input logic [2:0] m, input logic [3:0] r);
    logic [4:0] p;
    p = {1'b0, r};
    if (r >= 4'd8 && r != 4'd15) begin
      if (m == M_FIQ)
        p = 5'd16 + {1'b0, r} - 5'd8;
      else if (r >= 4'd13 && banked_mode(m))
        p = 5'd23 + {2'b00, m - 3'd2} * 5'd2 + {4'b0, r[0] ^ 1'b1};
    end
    return p;
  endfunction

  logic       exc_hit;
  logic [4:0] exc_p, wr_p, ra_p, rb_p;

  assign exc_hit = exc_take && banked_mode(exc_mode);
  assign exc_p   = phys(exc_mode, 4'd14);
  assign wr_p    = phys(mode_i, wr_idx);
  assign ra_p    = phys(mode_i, ra_idx);
  assign rb_p    = phys(mode_i, rb_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
      for (int i = 0; i < NSAVED; i++) saved[i] <= '0;
      cur_st <= CPSR_INIT;
    end else begin
      if (we) gpr[wr_p] <= wr_data;
      if (exc_hit) gpr[exc_p] <= exc_ret;
      if (cpsr_we) cur_st <= cpsr_wdata;
      if (spsr_we && banked_mode(mode_i)) saved[saved_slot(mode_i)] <= spsr_wdata;
      if (exc_hit) saved[saved_slot(exc_mode)] <= cur_st;
    end
  end

  function automatic logic [DW-1:0] rd(input logic [4:0] p, input logic [DW-1:0] stored);
    if (exc_hit && exc_p == p) return exc_ret;
    if (we && wr_p == p) return wr_data;
    return stored;
  endfunction

  assign ra_data = rd(ra_p, gpr[ra_p]);
  assign rb_data = rd(rb_p, gpr[rb_p]);
  assign cpsr_o  = cur_st;

  always_comb begin
    spsr_o = '0;
    if (banked_mode(mode_i)) begin
      if (exc_hit && exc_mode == mode_i) spsr_o = cur_st;
      else if (spsr_we) spsr_o = spsr_wdata;
      else spsr_o = saved[saved_slot(mode_i)];
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic [3:0]    ra_idx,
  input logic [DW-1:0] ra_data,
  input logic          we,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          cpsr_we,
  input logic [DW-1:0] cpsr_wdata,
  input logic [DW-1:0] cpsr_o,
  input logic          spsr_we,
  input logic [DW-1:0] spsr_o,
  input logic          exc_take,
  input logic [2:0]    exc_mode,
  input logic [DW-1:0] exc_ret
);
  logic user_m;
  assign user_m = !(mode_i >= 3'd1 && mode_i <= 3'd5);

  p_shared_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wr_idx) < 4'd8 && ra_idx == $past(wr_idx) && !we)
    |-> ra_data == $past(wr_data));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !exc_take && ra_idx == wr_idx) |-> ra_data == wr_data);

  p_user_spsr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    user_m |-> spsr_o == '0);

  p_exc_spsr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(exc_take) && $past(exc_mode) >= 3'd1 && $past(exc_mode) <= 3'd5 &&
     mode_i == $past(exc_mode) && !spsr_we && !exc_take)
    |-> spsr_o == $past(cpsr_o));

  p_exc_lr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(exc_take) && $past(exc_mode) >= 3'd1 && $past(exc_mode) <= 3'd5 &&
     mode_i == $past(exc_mode) && ra_idx == 4'd14 && !we && !exc_take)
    |-> ra_data == $past(exc_ret));

  p_cpsr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpsr_we)) |-> cpsr_o == $past(cpsr_wdata));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (.*);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int DW = 32;
  localparam logic [DW-1:0] INIT = 32'h0000_00D3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_i = '0, exc_mode = '0;
  logic [3:0] ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic we = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0, exc_take = 1'b0;
  logic [DW-1:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_ret = '0;
  logic [DW-1:0] ra_data, rb_data, cpsr_o, spsr_o;

  always #10 clk = ~clk;

  banked_regfile #(.DW(DW), .CPSR_INIT(INIT)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_gpr [31];
  logic [DW-1:0] m_sav [5];
  logic [DW-1:0] m_cur;

  function automatic bit exm(input logic [2:0] m);
    return m inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  endfunction

  function automatic int loc(input logic [2:0] m, input logic [3:0] r);
    if (r < 8 || r == 15) return int'(r);
    if (m == 3'd1) return 16 + int'(r) - 8;
    if (r < 13 || !exm(m)) return int'(r);
    case (m)
      3'd2: return (r == 13) ? 23 : 24;
      3'd3: return (r == 13) ? 25 : 26;
      3'd4: return (r == 13) ? 27 : 28;
      default: return (r == 13) ? 29 : 30;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [3:0] r);
    int p = loc(mode_i, r);
    if (exc_take && exm(exc_mode) && p == loc(exc_mode, 4'd14)) return exc_ret;
    if (we && p == loc(mode_i, wr_idx)) return wr_data;
    return m_gpr[p];
  endfunction

  function automatic logic [DW-1:0] exp_sav();
    if (!exm(mode_i)) return '0;
    if (exc_take && exc_mode == mode_i) return m_cur;
    if (spsr_we) return spsr_wdata;
    return m_sav[int'(mode_i) - 1];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    for (int i = 0; i < 5; i++) m_sav[i] = '0;
    m_cur = INIT;
  endtask

  task automatic step(input string tag);
    #2;
    check({tag, " port A"}, ra_data, exp_rd(ra_idx));
    check({tag, " port B"}, rb_data, exp_rd(rb_idx));
    check({tag, " saved status"}, spsr_o, exp_sav());
    check({tag, " status"}, cpsr_o, m_cur);
    @(posedge clk);
    begin
      logic [DW-1:0] old_cur = m_cur;
      if (we) m_gpr[loc(mode_i, wr_idx)] = wr_data;
      if (exc_take && exm(exc_mode)) m_gpr[loc(exc_mode, 4'd14)] = exc_ret;
      if (cpsr_we) m_cur = cpsr_wdata;
      if (spsr_we && exm(mode_i)) m_sav[int'(mode_i) - 1] = spsr_wdata;
      if (exc_take && exm(exc_mode)) m_sav[int'(exc_mode) - 1] = old_cur;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    we = 0; cpsr_we = 0; spsr_we = 0; exc_take = 0;
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] r, input logic [DW-1:0] d, input string tag);
    idle(); mode_i = m; we = 1; wr_idx = r; wr_data = d; step(tag); idle();
  endtask

  task automatic rd_chk(input logic [2:0] m, input logic [3:0] r, input logic [DW-1:0] e, input string tag);
    idle(); mode_i = m; ra_idx = r; #2; check(tag, ra_data, e); step(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("R1 status reset", cpsr_o, INIT);
    mode_i = 3'd1; #1;
    check("R1 saved reset", spsr_o, '0);
    mode_i = 3'd0; ra_idx = 4'd9; #1;
    check("R1 register reset", ra_data, '0);

    wr(3'd0, 4'd8, 32'hAAAA_0008, "R2");
    wr(3'd1, 4'd8, 32'hF1F1_0008, "R4");
    rd_chk(3'd0, 4'd8, 32'hAAAA_0008, "R4 user copy intact");
    rd_chk(3'd1, 4'd8, 32'hF1F1_0008, "R4 private copy");
    rd_chk(3'd2, 4'd8, 32'hAAAA_0008, "R5 shared R8 in irq");
    wr(3'd2, 4'd13, 32'h1111_0013, "R5");
    wr(3'd3, 4'd13, 32'h3333_0013, "R5");
    rd_chk(3'd2, 4'd13, 32'h1111_0013, "R5 irq stack");
    rd_chk(3'd0, 4'd13, 32'h0, "R5 user stack untouched");
    wr(3'd5, 4'd3, 32'h0303_0303, "R3");
    rd_chk(3'd1, 4'd3, 32'h0303_0303, "R3 shared low");
    wr(3'd4, 4'd15, 32'h0F0F_0F0F, "R3");
    rd_chk(3'd6, 4'd15, 32'h0F0F_0F0F, "R3 shared R15");

    idle(); cpsr_we = 1; cpsr_wdata = 32'hC0DE_0010; step("R9"); idle();
    #2; check("R9 status loaded", cpsr_o, 32'hC0DE_0010);

    // R8 clash: exception and write on abort R14, plus same-cycle read bypass
    idle(); mode_i = 3'd4; we = 1; wr_idx = 4'd14; wr_data = 32'hDEAD_0000;
    spsr_we = 1; spsr_wdata = 32'h5555_5555;
    exc_take = 1; exc_mode = 3'd4; exc_ret = 32'hE000_0004; ra_idx = 4'd14;
    #2; check("R8 exception wins bypass", ra_data, 32'hE000_0004);
    step("R8"); idle();
    rd_chk(3'd4, 4'd14, 32'hE000_0004, "R8 link loaded");
    #2; check("R8 saved status", spsr_o, 32'hC0DE_0010);

    idle(); mode_i = 3'd0; spsr_we = 1; spsr_wdata = 32'h7777_7777;
    #2; check("R7 user saved reads zero", spsr_o, '0); step("R7"); idle();
    mode_i = 3'd4; #2; check("R7 abort saved untouched", spsr_o, 32'hC0DE_0010);

    idle(); mode_i = 3'd0; exc_take = 1; exc_mode = 3'd7; exc_ret = 32'h9999_9999; step("R8"); idle();
    rd_chk(3'd0, 4'd14, 32'h0, "R8 user-target exception ignored");

    idle(); mode_i = 3'd2; we = 1; wr_idx = 4'd5; wr_data = 32'hB1B1_B1B1; rb_idx = 4'd5;
    #2; check("R6 bypass", rb_data, 32'hB1B1_B1B1); step("R6"); idle();

    void'($urandom(32'd12345));
    for (int n = 0; n < 3000; n++) begin
      mode_i = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 2) != 0);
      wr_idx = ($urandom_range(0, 1) != 0) ? 4'($urandom_range(12, 14)) : 4'($urandom_range(0, 15));
      wr_data = $urandom;
      ra_idx = ($urandom_range(0, 2) == 0) ? wr_idx : 4'($urandom_range(0, 15));
      rb_idx = ($urandom_range(0, 2) == 0) ? 4'd14 : 4'($urandom_range(0, 15));
      cpsr_we = ($urandom_range(0, 4) == 0);
      cpsr_wdata = $urandom;
      spsr_we = ($urandom_range(0, 3) == 0);
      spsr_wdata = $urandom;
      exc_take = ($urandom_range(0, 3) == 0);
      exc_mode = ($urandom_range(0, 1) != 0) ? mode_i : 3'($urandom_range(0, 7));
      exc_ret = $urandom;
      step("R2 R6 R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule